// File: doc/BRIEF.md
# SPI Receive Data Match Detector

This block sits beside the receive path of an SPI controller. It watches each word as it is received and raises a data-match event when the incoming stream fits a programmed pattern. The pattern is set by a 3-bit match mode and two match values, M0 and M1. Depending on the mode, the block compares either only the first word of a frame or every word. It looks for either a single word or a pair of consecutive words. In one pair of modes it does a masked comparison, in which M1 selects the bits that take part.

Each received word arrives with a one-cycle valid strobe. A start-of-frame flag marks the first word after chip select is asserted. The result is a registered, single-cycle match pulse, which is meant to set a sticky status flag elsewhere. The block does not hold or gate receive data. For the sequence modes it keeps one bit of pending state. That bit is dropped when the sequence breaks, when a new frame starts, or when the configuration changes.

Top module: `spi_rx_match_det`

## Requirements
- R1: With mode 0 or mode 1 (mode 1 is reserved), no match pulse is ever produced.
- R2: In mode 2, a word received with start-of-frame set matches when it equals M0 or M1. Words without start-of-frame never match.
- R3: In mode 3, any received word matches when it equals M0 or M1.
- R4: In mode 4, a match occurs on the word that follows a start-of-frame word equal to M0, when that following word equals M1. Idle cycles may lie between the two words.
- R5: In mode 5, a match occurs when a word equals M1 and the word received just before it equals M0. A non-matching word breaks the sequence. A breaking word that itself equals M0 arms a new sequence.
- R6: In mode 6, a start-of-frame word w matches when (w AND M1) equals (M0 AND M1).
- R7: In mode 7, any word w matches when (w AND M1) equals (M0 AND M1).
- R8: A word received with start-of-frame set never completes a two-word sequence begun in the previous frame.
- R9: The match pulse is high for exactly the one cycle after the clock edge that accepts the completing word. It is never high in a cycle that does not follow an accepted word.
- R10: Any change of mode, M0 or M1 discards a half-completed two-word sequence.
- R11: While reset is asserted and right after it is released, the match pulse is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 3 | Match mode, encoded 0 to 7 |
| cfg_m0 | input | WORD_W | Match value M0 |
| cfg_m1 | input | WORD_W | Match value M1, or the bit mask in modes 6 and 7 |
| rx_valid | input | 1 | Received word is valid this cycle |
| rx_word | input | WORD_W | Received word |
| rx_sof | input | 1 | Word is the first of its frame |
| match_pulse | output | 1 | One-cycle match event |

## Verification
The bench builds the block with the default 32-bit word width. This lets the masked modes use a mask whose set bits lie only in the upper half, so a word can differ from M0 in its low half and still match. The same word can then be shown failing when a masked bit differs. With full-width values, M0 and M1 are distinct patterns, so the bench can feed sequences that break, re-arm, cross a frame boundary, or straddle a configuration change, and predict each outcome from the requirements alone.

// File: rtl/spi_match_pkg.sv
package spi_match_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MM_OFF        = 3'd0,
      MM_RSVD       = 3'd1,
      MM_FIRST_EQ   = 3'd2,
      MM_ANY_EQ     = 3'd3,
      MM_FIRST_PAIR = 3'd4,
      MM_ANY_PAIR   = 3'd5,
      MM_FIRST_MASK = 3'd6,
      MM_ANY_MASK   = 3'd7
   } match_mode_e;

   function automatic logic is_pair_mode(match_mode_e m);
      return (m == MM_FIRST_PAIR) || (m == MM_ANY_PAIR);
   endfunction

endpackage

// File: rtl/spi_match_cmp.sv
module spi_match_cmp #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] m0,
   input  logic [WORD_W-1:0] m1,
   output logic              eq_m0,
   output logic              eq_m1,
   output logic              eq_masked
);

   if (WORD_W < 1) begin : g_bad_width
      $error("spi_match_cmp: WORD_W must be at least 1");
   end

   logic [WORD_W-1:0] diff0;

   assign diff0     = word ^ m0;
   assign eq_m0     = (diff0 == '0);
   assign eq_m1     = ((word ^ m1) == '0);
   assign eq_masked = ((diff0 & m1) == '0);

endmodule

// File: rtl/spi_match_cfg_track.sv
module spi_match_cfg_track #(
   parameter int WORD_W = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [spi_match_pkg::MODE_W-1:0]   mode,
   input  logic [WORD_W-1:0]                  m0,
   input  logic [WORD_W-1:0]                  m1,
   output logic                               cfg_chg
);

   localparam int CFG_W = spi_match_pkg::MODE_W + 2 * WORD_W;

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;

   assign cfg_now = {mode, m0, m1};
   assign cfg_chg = (cfg_now != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

endmodule

// File: rtl/spi_match_seq.sv
module spi_match_seq
   import spi_match_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  match_mode_e mode,
   input  logic        rx_valid,
   input  logic        rx_sof,
   input  logic        eq_m0,
   input  logic        eq_m1,
   input  logic        cfg_chg,
   output logic        pair_hit
);

   logic pend_q;
   logic pend_d;
   logic pend_live;

   // a pending first word survives only inside its frame and configuration
   assign pend_live = pend_q && !cfg_chg && !rx_sof;
   assign pair_hit  = rx_valid && pend_live && eq_m1 && is_pair_mode(mode);

   always_comb begin
      pend_d = pend_q && !cfg_chg && is_pair_mode(mode);
      if (rx_valid) begin
         unique case (mode)
            MM_FIRST_PAIR: pend_d = rx_sof && eq_m0;
            MM_ANY_PAIR:   pend_d = eq_m0;
            default:       pend_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   // R8: a start-of-frame word that is not M0 leaves nothing pending
   a_r8_sof_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_sof && !eq_m0) |=> !pend_q);

   // R10: a configuration change with no word present clears pending state
   a_r10_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chg && !rx_valid) |=> !pend_q);

   // R1: non-pair modes never hold pending state
   a_r1_no_pend_outside_pairs: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_pair_mode(mode)) |=> !pend_q);

endmodule

// File: rtl/spi_rx_match_det.sv
module spi_rx_match_det
   import spi_match_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [MODE_W-1:0]     cfg_mode,
   input  logic [WORD_W-1:0]     cfg_m0,
   input  logic [WORD_W-1:0]     cfg_m1,
   input  logic                  rx_valid,
   input  logic [WORD_W-1:0]     rx_word,
   input  logic                  rx_sof,
   output logic                  match_pulse
);

   if (WORD_W < 2) begin : g_bad_width
      $error("spi_rx_match_det: WORD_W must be at least 2");
   end

   match_mode_e mode;
   logic        eq_m0;
   logic        eq_m1;
   logic        eq_masked;
   logic        cfg_chg;
   logic        pair_hit;
   logic        single_hit;
   logic        hit;
   logic        pulse_q;

   assign mode = match_mode_e'(cfg_mode);

   spi_match_cmp #(.WORD_W(WORD_W)) u_cmp (
      .word      (rx_word),
      .m0        (cfg_m0),
      .m1        (cfg_m1),
      .eq_m0     (eq_m0),
      .eq_m1     (eq_m1),
      .eq_masked (eq_masked)
   );

   spi_match_cfg_track #(.WORD_W(WORD_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (cfg_mode),
      .m0      (cfg_m0),
      .m1      (cfg_m1),
      .cfg_chg (cfg_chg)
   );

   spi_match_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .rx_valid (rx_valid),
      .rx_sof   (rx_sof),
      .eq_m0    (eq_m0),
      .eq_m1    (eq_m1),
      .cfg_chg  (cfg_chg),
      .pair_hit (pair_hit)
   );

   always_comb begin
      unique case (mode)
         MM_FIRST_EQ:   single_hit = rx_sof && (eq_m0 || eq_m1);
         MM_ANY_EQ:     single_hit = eq_m0 || eq_m1;
         MM_FIRST_MASK: single_hit = rx_sof && eq_masked;
         MM_ANY_MASK:   single_hit = eq_masked;
         default:       single_hit = 1'b0;
      endcase
   end

   assign hit = rx_valid && (single_hit || pair_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit;
   end

   assign match_pulse = pulse_q;

   // R9: a pulse always follows an accepted word
   a_r9_pulse_after_word: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(rx_valid));

   // R1: disabled and reserved modes stay silent
   a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> ($past(cfg_mode) > 3'd1));

   // R2 / R6: first-word modes only fire on a start-of-frame word
   a_r2_first_only: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && ($past(mode) == MM_FIRST_EQ || $past(mode) == MM_FIRST_MASK))
      |-> $past(rx_sof));

   // R4 / R8: the completing word of a pair is never a start-of-frame word
   a_r4_pair_not_sof: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && is_pair_mode($past(mode))) |-> !$past(rx_sof));

endmodule

// File: tb/spi_rx_match_det_bench.sv
module spi_rx_match_det_bench;

   localparam int CLK_P  = 10;
   localparam int WORD_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        cfg_mode = '0;
   logic [WORD_W-1:0] cfg_m0 = '0;
   logic [WORD_W-1:0] cfg_m1 = '0;
   logic              rx_valid = 1'b0;
   logic [WORD_W-1:0] rx_word = '0;
   logic              rx_sof = 1'b0;
   logic              match_pulse;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit mdl_pend = 1'b0;

   bit    q_exp[$];
   string q_tag[$];

   spi_rx_match_det #(.WORD_W(WORD_W)) u_spi_rx_match_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_mode    (cfg_mode),
      .cfg_m0      (cfg_m0),
      .cfg_m1      (cfg_m1),
      .rx_valid    (rx_valid),
      .rx_word     (rx_word),
      .rx_sof      (rx_sof),
      .match_pulse (match_pulse)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input bit act, input bit exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: match_pulse=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic set_cfg(input logic [2:0] m, input logic [WORD_W-1:0] a,
                          input logic [WORD_W-1:0] b);
      @(negedge clk);
      rx_valid = 1'b0;
      cfg_mode = m;
      cfg_m0   = a;
      cfg_m1   = b;
      mdl_pend = 1'b0;   // R10: any change drops a half sequence
   endtask

   task automatic send(input logic [WORD_W-1:0] w, input bit sof, input string tag);
      bit e0, e1, em, exp, pn;
      @(negedge clk);
      rx_valid = 1'b1;
      rx_word  = w;
      rx_sof   = sof;
      e0 = (w == cfg_m0);
      e1 = (w == cfg_m1);
      em = (((w ^ cfg_m0) & cfg_m1) == '0);
      exp = 1'b0;
      pn  = 1'b0;
      case (cfg_mode)
         3'd2: exp = sof && (e0 || e1);
         3'd3: exp = e0 || e1;
         3'd4: begin exp = mdl_pend && !sof && e1; pn = sof && e0; end
         3'd5: begin exp = mdl_pend && !sof && e1; pn = e0; end
         3'd6: exp = sof && em;
         3'd7: exp = em;
         default: exp = 1'b0;
      endcase
      mdl_pend = pn;
      q_exp.push_back(exp);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b0;
         rx_sof   = 1'b0;
      end
   endtask

   // monitor: compares each accepted word's outcome one cycle later
   initial begin
      forever begin
         bit v;
         @(posedge clk);
         v = rx_valid && rst_n;
         #(CLK_P/4);
         if (v) begin
            if (q_exp.size() == 0) begin
               failures++;
               $display("FAIL R9: match_pulse=%0b expected=<no item> at %0t", match_pulse, $time);
            end else begin
               bit e;
               string t;
               e = q_exp.pop_front();
               t = q_tag.pop_front();
               check(match_pulse, e, t);
            end
         end else begin
            check(match_pulse, 1'b0, "R9");
         end
      end
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         failures++;
         $display("FAIL watchdog: cycles=%0d expected=<done>", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   localparam logic [WORD_W-1:0] A = 32'h1111_1111;
   localparam logic [WORD_W-1:0] B = 32'h2222_2222;
   localparam logic [WORD_W-1:0] X = 32'h3333_3333;

   initial begin
      #(CLK_P/4);
      check(match_pulse, 1'b0, "R11");
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #(CLK_P/4);
      check(match_pulse, 1'b0, "R11");

      // R1: disabled and reserved modes
      set_cfg(3'd0, A, B);
      send(A, 1, "R1"); send(B, 0, "R1"); idle(1);
      set_cfg(3'd1, A, B);
      send(A, 1, "R1"); send(B, 0, "R1"); send(A, 0, "R1"); idle(2);

      // R2: first word equals M0 or M1
      set_cfg(3'd2, A, B);
      send(B, 1, "R2"); send(A, 0, "R2"); idle(1);
      send(X, 1, "R2"); send(A, 1, "R2"); idle(2);

      // R3: any word
      set_cfg(3'd3, A, B);
      send(X, 1, "R3"); send(A, 0, "R3"); send(B, 0, "R3"); send(X, 0, "R3"); idle(2);

      // R4: first M0 then second M1
      set_cfg(3'd4, A, B);
      send(A, 1, "R4"); send(B, 0, "R4"); idle(1);
      send(A, 1, "R4"); idle(3); send(B, 0, "R4"); idle(1);
      send(A, 1, "R4"); send(X, 0, "R4"); send(B, 0, "R4"); idle(1);
      send(X, 1, "R4"); send(A, 0, "R4"); send(B, 0, "R4"); idle(1);
      send(A, 1, "R8"); send(B, 1, "R8"); idle(2);

      // R10: mode change between the two words
      send(A, 1, "R10");
      set_cfg(3'd5, A, B);
      send(B, 0, "R10"); idle(1);

      // R5: any M0 followed directly by M1
      send(A, 1, "R5"); send(B, 0, "R5"); idle(1);
      send(A, 0, "R5"); send(X, 0, "R5"); send(B, 0, "R5"); idle(1);
      send(A, 0, "R5"); send(A, 0, "R5"); send(B, 0, "R5"); idle(1);
      send(A, 0, "R8"); send(B, 1, "R8"); idle(1);

      // R10: match value change between the two words
      send(A, 0, "R10");
      set_cfg(3'd5, A, X);
      send(X, 0, "R10"); idle(1);
      send(A, 0, "R5"); send(X, 0, "R5"); idle(2);

      // R6: masked first word, mask on upper half
      set_cfg(3'd6, 32'h1234_5678, 32'hFFFF_0000);
      send(32'h1234_ABCD, 1, "R6"); send(32'h1234_ABCD, 0, "R6"); idle(1);
      send(32'h1235_5678, 1, "R6"); idle(2);

      // R7: masked any word
      set_cfg(3'd7, 32'h1234_5678, 32'hFFFF_0000);
      send(32'h0000_5678, 1, "R7"); send(32'h1234_0000, 0, "R7");
      send(32'h1234_FFFF, 0, "R7"); idle(3);

      idle(3);
      if (q_exp.size() != 0) begin
         failures++;
         $display("FAIL R9: pending=%0d expected=0", q_exp.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule